// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimate Unit

This block produces a low-precision approximation of 1/x for a 32-bit IEEE single-precision operand. It is meant to seed a later refinement loop inside a floating-point pipeline, so the answer does not come from a real division. Eight fraction bits are taken from the operand, and a fixed 9-bit integer recipe turns them into eight result fraction bits. The result exponent is the operand exponent reflected about 253.

The operand arrives with a 2-bit rounding mode and two mode bits. One mode bit flushes denormals to zero. The other selects the default NaN. The unit handles NaN, infinity, zero, operands too small to invert, results the flush mode forces to zero, denormal operands and denormal results. It raises six exception flags. The datapath is combinational and is followed by one register stage qualified by a valid strobe.

Top module: `recip_est`

## Requirements
- R1: While reset is asserted, and afterwards until the first accepted operand, `out_valid`, `out_data` and `out_flags` are all zero.
- R2: An operand presented with `in_valid` high appears on `out_data`/`out_flags` one clock later, with `out_valid` high. When `in_valid` is low, `out_valid` goes low one clock later and `out_data`/`out_flags` keep their previous values.
- R3: For a normal operand with exponent field e in 1..252, the result keeps the operand sign and has exponent field 253-e. Its fraction bits [22:15] hold the low 8 bits of r, and bits [14:0] are zero. Here r = ((2^19 / (2·m+1)) + 1) >> 1 with integer division, and m = 256 + fraction bits [22:15]. No flag is raised.
- R4: With flush mode off, a denormal operand whose fraction is at least 2^21 is normalised before the estimate. If fraction bit 22 is set, the fraction is shifted left 1 and the effective exponent is 0 (result exponent 253). Otherwise it is shifted left 2 and the effective exponent is -1 (result exponent 254).
- R5: When 253 minus the effective exponent is 0, the result exponent field is 0 and the fraction is {1, r[7:0], 14 zeros}. When it is -1, the exponent field is 0 and the fraction is {01, r[7:0], 13 zeros}.
- R6: For a NaN operand, a signalling NaN (fraction bit 22 clear) raises invalid. The output is the operand with fraction bit 22 set. When default-NaN mode is on, the output is 0x7FC00000 instead.
- R7: An infinite operand gives a zero of the same sign and no flag.
- R8: A zero operand gives an infinity of the same sign and raises divide-by-zero.
- R9: A nonzero operand with magnitude bits below 2^21 raises overflow and inexact. The output is a signed infinity when the rounding mode rounds toward infinity for that sign, and the signed value 0x7F7FFFFF otherwise. Rounding mode encoding: 0 nearest (always infinity), 1 toward +inf (infinity for positive only), 2 toward -inf (infinity for negative only), 3 toward zero (never infinity).
- R10: With flush mode on, a finite operand with exponent field 253 or 254 raises underflow and gives a zero of the same sign.
- R11: With flush mode on, a denormal operand raises input-denormal and is then treated as a zero of the same sign (R8 applies).
- R12: Flag bit positions in `out_flags`: [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact, [5] input-denormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode (0 nearest, 1 +inf, 2 -inf, 3 zero) |
| in_ftz | input | 1 | Flush denormals to zero |
| in_dnan | input | 1 | Return the default NaN for NaN operands |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | Reciprocal estimate |
| out_flags | output | 6 | Exception flags |

## Verification
Every result, for every operand class, is due exactly one rising edge after the edge that sees `in_valid` high. The bench sets inputs on a falling edge and reads the outputs on the next falling edge, midway between the capturing edge and the one after it. Idle cycles are checked one falling edge after `in_valid` drops: `out_valid` must be low and the previous result must still be present. Because the reset is released through an internal two-flop synchroniser, the bench waits several cycles after releasing reset before it presents the first operand.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  localparam int unsigned FP_W    = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned EST_W   = 9;
  localparam int unsigned FLAG_W  = 6;
  localparam int unsigned LOOKUP_W = EST_W - 1;

  localparam logic [EXP_W-1:0] EXP_MAX  = '1;
  localparam logic [EXP_W-1:0] EXP_BIAS2 = 8'd253;

  localparam int unsigned FL_INV = 0;
  localparam int unsigned FL_DZ  = 1;
  localparam int unsigned FL_OVF = 2;
  localparam int unsigned FL_UNF = 3;
  localparam int unsigned FL_INX = 4;
  localparam int unsigned FL_IDN = 5;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_POS     = 2'd1,
    RM_NEG     = 2'd2,
    RM_ZERO    = 2'd3
  } rmode_e;

  localparam logic [FP_W-1:0] DEFAULT_NAN = 32'h7FC0_0000;
  localparam logic [FP_W-2:0] MAX_FINITE  = 31'h7F7F_FFFF;

endpackage

// File: rtl/recip_est_core.sv
module recip_est_core #(
  parameter int unsigned EST_W = 9
) (
  input  logic [EST_W-2:0] frac_top,
  output logic [EST_W-2:0] est_low
);
  localparam int unsigned DEN_W = EST_W + 1;
  localparam int unsigned NUM_W = 2 * EST_W + 2;

  // Leading one of the operand and of the estimate are implicit.
  function automatic logic [EST_W-2:0] estimate(input logic [EST_W-2:0] t);
    logic [DEN_W-1:0] den;
    logic [NUM_W-1:0] num;
    logic [DEN_W:0]   rem;
    logic [NUM_W-1:0] quo;
    logic [NUM_W-1:0] rnd;
    den = {1'b1, t, 1'b1};
    num = '0;
    num[NUM_W-1] = 1'b1;
    rem = '0;
    quo = '0;
    for (int i = NUM_W - 1; i >= 0; i--) begin
      rem = {rem[DEN_W-1:0], num[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
    rnd = (quo + 1'b1) >> 1;
    return rnd[EST_W-2:0];
  endfunction

  always_comb est_low = estimate(frac_top);

endmodule

// File: rtl/recip_est_special.sv
module recip_est_special
  import recip_est_pkg::*;
(
  input  logic [FP_W-1:0]   x,
  input  logic [1:0]        rmode,
  input  logic              ftz,
  input  logic              dnan,
  output logic [FP_W-1:0]   res,
  output logic [FLAG_W-1:0] flg
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              squash;
  logic [FRAC_W-1:0] fr_eff;
  logic              is_nan, is_inf, is_zero, is_tiny, is_big;
  logic              to_inf;
  logic              eff_neg;
  logic [LOOKUP_W-1:0] top8;
  logic [LOOKUP_W-1:0] est;
  logic [EXP_W+1:0]  rexp;
  logic              r_den0, r_denm1;

  assign sgn = x[FP_W-1];
  assign ex  = x[FP_W-2:FRAC_W];
  assign fr  = x[FRAC_W-1:0];

  assign squash  = ftz && (ex == '0) && (fr != '0);
  assign fr_eff  = squash ? '0 : fr;
  assign is_nan  = (ex == EXP_MAX) && (fr != '0);
  assign is_inf  = (ex == EXP_MAX) && (fr == '0);
  assign is_zero = (ex == '0) && (fr_eff == '0);
  assign is_tiny = (ex == '0) && (fr_eff[FRAC_W-1:FRAC_W-2] == 2'b00);
  assign is_big  = ftz && (ex >= EXP_BIAS2);

  always_comb begin
    unique case (rmode_e'(rmode))
      RM_NEAREST: to_inf = 1'b1;
      RM_POS:     to_inf = !sgn;
      RM_NEG:     to_inf = sgn;
      default:    to_inf = 1'b0;
    endcase
  end

  // Denormal operand normalisation.
  assign eff_neg = (ex == '0) && !fr[FRAC_W-1];
  always_comb begin
    if (ex != '0)            top8 = fr[FRAC_W-1:FRAC_W-LOOKUP_W];
    else if (fr[FRAC_W-1])   top8 = fr[FRAC_W-2:FRAC_W-LOOKUP_W-1];
    else                     top8 = fr[FRAC_W-3:FRAC_W-LOOKUP_W-2];
  end

  recip_est_core #(.EST_W(EST_W)) u_core (
    .frac_top (top8),
    .est_low  (est)
  );

  assign rexp    = {2'b00, EXP_BIAS2} - {2'b00, ex} + {{(EXP_W+1){1'b0}}, eff_neg};
  assign r_den0  = (rexp == '0);
  assign r_denm1 = (rexp == '1);

  always_comb begin
    res = '0;
    flg = '0;
    flg[FL_IDN] = squash;
    if (is_nan) begin
      flg[FL_INV] = !fr[FRAC_W-1];
      res = dnan ? DEFAULT_NAN : (x | (32'h1 << (FRAC_W - 1)));
    end else if (is_inf) begin
      res = {sgn, {(FP_W-1){1'b0}}};
    end else if (is_zero) begin
      flg[FL_DZ] = 1'b1;
      res = {sgn, EXP_MAX, {FRAC_W{1'b0}}};
    end else if (is_tiny) begin
      flg[FL_OVF] = 1'b1;
      flg[FL_INX] = 1'b1;
      res = to_inf ? {sgn, EXP_MAX, {FRAC_W{1'b0}}} : {sgn, MAX_FINITE};
    end else if (is_big) begin
      flg[FL_UNF] = 1'b1;
      res = {sgn, {(FP_W-1){1'b0}}};
    end else if (r_den0) begin
      res = {sgn, {EXP_W{1'b0}}, 1'b1, est, {(FRAC_W-LOOKUP_W-1){1'b0}}};
    end else if (r_denm1) begin
      res = {sgn, {EXP_W{1'b0}}, 2'b01, est, {(FRAC_W-LOOKUP_W-2){1'b0}}};
    end else begin
      res = {sgn, rexp[EXP_W-1:0], est, {(FRAC_W-LOOKUP_W){1'b0}}};
    end
  end

endmodule

// File: rtl/recip_est.sv
module recip_est
  import recip_est_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  input  logic [1:0]        in_rmode,
  input  logic              in_ftz,
  input  logic              in_dnan,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic [5:0]        out_flags
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [FP_W-1:0]   comb_res;
  logic [FLAG_W-1:0] comb_flg;
  logic              valid_d, valid_q;
  logic [FP_W-1:0]   data_d, data_q;
  logic [FLAG_W-1:0] flg_d, flg_q;
  logic              cap_en;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  recip_est_special u_special (
    .x     (in_data),
    .rmode (in_rmode),
    .ftz   (in_ftz),
    .dnan  (in_dnan),
    .res   (comb_res),
    .flg   (comb_flg)
  );

  assign cap_en = in_valid;

  always_comb begin
    valid_d = in_valid;
    data_d  = data_q;
    flg_d   = flg_q;
    if (cap_en) begin
      data_d = comb_res;
      flg_d  = comb_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      flg_q   <= flg_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_flags = flg_q;

endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic [5:0]  out_flags
);
  logic in_is_nan, in_is_inf;
  assign in_is_nan = (in_data[30:23] == 8'hFF) && (in_data[22:0] != 23'h0);
  assign in_is_inf = (in_data[30:0] == 31'h7F80_0000);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_flags)));
  p_sign_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_nan) |=> (out_data[31] == $past(in_data[31])));
  p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[0]) |-> (out_data[30:22] == 9'h1FF));
  p_inf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_inf) |=> ((out_data[30:0] == 31'h0) && (out_flags == 6'h0)));
  p_dz_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_data[30:0] == 31'h7F80_0000));
  p_ovf_inx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> out_flags[4]);
  p_unf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[3]) |-> (out_data[30:0] == 31'h0));
  p_idn_dz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[5]) |-> out_flags[1]);

endmodule

bind recip_est recip_est_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_flags (out_flags)
);

// File: tb/recip_est_test.sv
`timescale 1ns/1ps
module recip_est_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [1:0]  in_rmode;
  logic        in_ftz, in_dnan;
  logic        out_valid;
  logic [31:0] out_data;
  logic [5:0]  out_flags;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  recip_est uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_rmode(in_rmode), .in_ftz(in_ftz), .in_dnan(in_dnan),
    .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Expected {flags, data} from the requirements.
  function automatic logic [37:0] model(input logic [31:0] x, input logic [1:0] rm,
                                        input logic ftz, input logic dn);
    logic s; logic [7:0] e; logic [22:0] f; logic [5:0] fl; logic [31:0] r;
    int ee; logic [22:0] nf; int m; int q; int est; int re; logic up;
    s = x[31]; e = x[30:23]; f = x[22:0]; fl = '0; r = '0;
    if (ftz && e == 0 && f != 0) begin f = '0; fl[5] = 1'b1; end        // R11
    if (e == 8'hFF && f != 0) begin                                      // R6
      if (!f[22]) fl[0] = 1'b1;
      r = dn ? 32'h7FC00000 : (x | 32'h00400000);
    end else if (e == 8'hFF) r = {s, 31'h0};                             // R7
    else if (e == 0 && f == 0) begin fl[1] = 1'b1; r = {s, 8'hFF, 23'h0}; end // R8
    else if (e == 0 && f < 23'h200000) begin                             // R9
      fl[2] = 1'b1; fl[4] = 1'b1;
      up = (rm == 2'd0) || (rm == 2'd1 && !s) || (rm == 2'd2 && s);
      r = up ? {s, 8'hFF, 23'h0} : {s, 31'h7F7FFFFF};
    end else if (ftz && e >= 8'd253) begin fl[3] = 1'b1; r = {s, 31'h0}; end // R10
    else begin
      if (e != 0) begin ee = int'(e); nf = f; end
      else if (f[22]) begin ee = 0; nf = f << 1; end                     // R4
      else begin ee = -1; nf = f << 2; end
      m   = 256 + int'(nf[22:15]);
      q   = (1 << 19) / (2 * m + 1);
      est = (q + 1) / 2;
      re  = 253 - ee;
      if (re == 0)       r = {s, 8'h00, 1'b1, est[7:0], 14'h0};          // R5
      else if (re == -1) r = {s, 8'h00, 2'b01, est[7:0], 13'h0};
      else               r = {s, re[7:0], est[7:0], 15'h0};              // R3
    end
    return {fl, r};
  endfunction

  task automatic run_one(input string req, input logic [31:0] x, input logic [1:0] rm,
                         input logic ftz, input logic dn);
    logic [37:0] e;
    e = model(x, rm, ftz, dn);
    @(negedge clk);
    in_valid = 1'b1; in_data = x; in_rmode = rm; in_ftz = ftz; in_dnan = dn;
    @(negedge clk);
    chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
    chk({req, " data"}, 64'(out_data), 64'(e[31:0]));
    chk({req, " R12 flags"}, 64'(out_flags), 64'(e[37:32]));
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] held_d; logic [5:0] held_f;
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_rmode = '0; in_ftz = 1'b0; in_dnan = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    chk("R1 data in reset", 64'(out_data), 64'd0);
    chk("R1 flags in reset", 64'(out_flags), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", 64'(out_valid), 64'd0);
    chk("R1 data after reset", 64'(out_data), 64'd0);

    run_one("R3 one",       32'h3F800000, 2'd0, 1'b0, 1'b0);
    chk("R3 one literal", 64'(out_data), 64'h3F7F8000);
    run_one("R3 three-halves", 32'h3FC00000, 2'd0, 1'b0, 1'b0);
    chk("R3 1.5 literal", 64'(out_data), 64'h3F2A8000);
    run_one("R3 neg two",   32'hC0000000, 2'd3, 1'b0, 1'b0);
    chk("R3 -2 literal", 64'(out_data), 64'hBEFF8000);

    // R2 hold: idle cycle keeps the last result, valid low.
    held_d = out_data; held_f = out_flags;
    in_data = 32'h12345678;
    @(negedge clk);
    chk("R2 idle valid", 64'(out_valid), 64'd0);
    chk("R2 idle data hold", 64'(out_data), 64'(held_d));
    chk("R2 idle flags hold", 64'(out_flags), 64'(held_f));

    run_one("R4 denorm f22", 32'h00600000, 2'd0, 1'b0, 1'b0);
    run_one("R4 denorm f21", 32'h80300000, 2'd0, 1'b0, 1'b0);
    run_one("R5 exp253",     32'h7E800000, 2'd0, 1'b0, 1'b0);
    run_one("R5 exp254",     32'hFF000000, 2'd0, 1'b0, 1'b0);
    run_one("R6 snan",       32'h7F800001, 2'd0, 1'b0, 1'b0);
    chk("R6 snan literal", 64'(out_data), 64'h7FC00001);
    run_one("R6 qnan dn",    32'hFFC01234, 2'd0, 1'b0, 1'b1);
    chk("R6 default nan literal", 64'(out_data), 64'h7FC00000);
    run_one("R7 neg inf",    32'hFF800000, 2'd0, 1'b0, 1'b0);
    run_one("R8 neg zero",   32'h80000000, 2'd0, 1'b0, 1'b0);
    chk("R8 literal", 64'(out_data), 64'hFF800000);
    for (int rm = 0; rm < 4; rm++) begin
      run_one("R9 tiny pos", 32'h001FFFFF, 2'(rm), 1'b0, 1'b0);
      run_one("R9 tiny neg", 32'h80000001, 2'(rm), 1'b0, 1'b0);
    end
    run_one("R10 flush big", 32'h7EFFFFFF, 2'd0, 1'b1, 1'b0);
    chk("R10 literal", 64'(out_flags), 64'h08);
    run_one("R11 flush denorm", 32'h80600000, 2'd0, 1'b1, 1'b0);
    chk("R11 literal", 64'(out_flags), 64'h22);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e; logic [22:0] f; logic [31:0] x;
      case ($urandom % 8)
        0: e = 8'd0;
        1: e = 8'd253;
        2: e = 8'd254;
        3: e = 8'd255;
        4: e = 8'd1;
        default: e = 8'(1 + ($urandom % 252));
      endcase
      f = ($urandom % 5 == 0) ? 23'h0 : 23'($urandom);
      if ($urandom % 6 == 0) f = f >> ($urandom % 23);
      x = {1'($urandom), e, f};
      run_one("R3 random", x, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule